// File: doc/BRIEF.md
# Configuration Shadow Reload and Interrupt Unit

This block holds two copies of a display controller's layer and timing settings. Software writes only to the shadow copy. The pixel pipeline reads only the active copy. A reload request moves the whole shadow copy into the active copy in one cycle. There are two kinds of request. An immediate request is served on the next clock. A deferred request waits for the next vertical-blanking strobe, so that a new configuration never takes effect partway through a frame.

The same block also keeps the controller's sticky event flags:
- a line-position match,
- a FIFO underrun,
- a bus transfer error,
- completion of a reload.

A per-flag enable mask selects which flags drive the interrupt line. Software reads the flags and clears them by writing ones to a separate clear register. It can write back the value it just read.

The block has a small write port with its own address space:

| Address | Register |
|---|---|
| 0 to NUM_CFG-1 | Shadow configuration words |
| NUM_CFG | Reload request |
| NUM_CFG+1 | Interrupt enable |
| NUM_CFG+2 | Flag clear |

Top module: `shadow_reload_irq`

## Requirements
- R1: While reset is asserted and immediately after it is released, every active word, every status flag, every enable bit, both pending-request bits and the interrupt line are 0.
- R2: A write to a shadow word (address 0 to NUM_CFG-1) leaves the active configuration unchanged. A vertical-blanking strobe with no deferred request pending also leaves it unchanged.
- R3: Writing 1 to bit 0 of the reload register (address NUM_CFG) sets pending bit 0 after that edge. At the following edge all active words take the shadow values and pending bit 0 returns to 0.
- R4: Writing 1 to bit 1 of the reload register sets pending bit 1. The bit stays set until a clock edge at which the vertical-blanking input is 1 and the bit was already set. At that edge the copy is made and the bit clears. A strobe at the same edge as the write does not serve the request.
- R5: When both request bits are pending together, the immediate copy serves both, and both pending bits clear at the same edge.
- R6: Every completed copy, of either kind, sets status bit 3 (reload done) at the edge of the copy.
- R7: A one-cycle pulse on the line-match, FIFO-underrun or transfer-error input sets status bit 0, 1 or 2 respectively. The bit stays set until it is cleared.
- R8: A write to the clear register (address NUM_CFG+2) clears each status bit whose data bit is 1 and leaves the other status bits unchanged.
- R9: If a clear and a new event hit the same status bit at the same edge, the bit ends up set.
- R10: The interrupt-enable register (address NUM_CFG+1) uses the status bit positions. The interrupt output is 1 exactly when some status bit and its enable bit are both 1. With IRQ_REG=0 it follows in the same cycle; with IRQ_REG=1 it follows one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the block's registers |
| wr_addr | input | ADDR_W | Write address (shadow words, reload, enable, clear) |
| wr_data | input | DATA_W | Write data |
| vblank_i | input | 1 | Vertical-blanking strobe |
| line_hit_i | input | 1 | Line-position match pulse |
| fifo_urun_i | input | 1 | FIFO underrun pulse |
| xfer_err_i | input | 1 | Bus transfer error pulse |
| act_cfg_o | output | NUM_CFG*DATA_W | Active configuration, word i at bits [i*DATA_W +: DATA_W] |
| irq_o | output | 1 | Interrupt request |
| status_o | output | 4 | Sticky flags {reload, xfer err, underrun, line} |
| irq_en_o | output | 4 | Interrupt enable mask |
| reload_pend_o | output | 2 | Pending requests {deferred, immediate} |

## Verification
The bench builds the block with NUM_CFG=4, DATA_W=16 and IRQ_REG=0. Four words are enough to check that every word moves together on a copy. Sixteen-bit data lets each word carry a distinct pattern. The same-cycle interrupt output lets every vector compare status, mask and interrupt at one sampling point. With three address bits, the reload, enable and clear registers sit at 4, 5 and 6. The vectors reach the race between a clear and an event, a strobe that lands on the request edge, and the overlap of both request kinds.

// File: rtl/shr_pkg.sv
package shr_pkg;
   localparam int NFLAG    = 4;
   localparam int FLG_LINE = 0;
   localparam int FLG_URUN = 1;
   localparam int FLG_XERR = 2;
   localparam int FLG_RLD  = 3;
   localparam int RLD_NOW  = 0;
   localparam int RLD_VBL  = 1;
   typedef logic [NFLAG-1:0] flag_t;
endpackage

// File: rtl/shr_cfg_bank.sv
module shr_cfg_bank #(
   parameter int NUM_CFG = 4,
   parameter int DATA_W  = 16
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [NUM_CFG-1:0]        wr_sel,
   input  logic [DATA_W-1:0]         wr_data,
   input  logic                      copy_i,
   output logic [NUM_CFG*DATA_W-1:0] act_o
);
   // one shadow/active pair per configuration word
   for (genvar w = 0; w < NUM_CFG; w++) begin : g_word
      logic [DATA_W-1:0] shadow_q;
      logic [DATA_W-1:0] active_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            shadow_q <= '0;
         end else if (wr_sel[w]) begin
            shadow_q <= wr_data;
         end
      end

      // the copy takes the shadow value held before this edge
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            active_q <= '0;
         end else if (copy_i) begin
            active_q <= shadow_q;
         end
      end

      assign act_o[w*DATA_W +: DATA_W] = active_q;
   end
endmodule

// File: rtl/shr_reload_seq.sv
module shr_reload_seq
   import shr_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       req_we,
   input  logic [1:0] req_bits,
   input  logic       vblank_i,
   output logic [1:0] pend_o,
   output logic       copy_o
);
   logic imm_q, vbl_q;
   logic imm_d, vbl_d;
   logic vbl_hit;

   assign vbl_hit = vbl_q & vblank_i;
   assign copy_o  = imm_q | vbl_hit;

   always_comb begin
      imm_d = imm_q;
      vbl_d = vbl_q;
      // an immediate copy also satisfies an outstanding deferred request
      if (imm_q) begin
         imm_d = 1'b0;
         vbl_d = 1'b0;
      end else if (vbl_hit) begin
         vbl_d = 1'b0;
      end
      // a new request written on the completion edge stays pending
      if (req_we && req_bits[RLD_NOW]) imm_d = 1'b1;
      if (req_we && req_bits[RLD_VBL]) vbl_d = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         imm_q <= 1'b0;
         vbl_q <= 1'b0;
      end else begin
         imm_q <= imm_d;
         vbl_q <= vbl_d;
      end
   end

   assign pend_o = {vbl_q, imm_q};

   // R3: an immediate request clears itself one edge after it was set
   assert_imm_selfclear_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (imm_q && !(req_we && req_bits[RLD_NOW])) |=> !imm_q);

   // R4: a deferred request survives every edge without a blanking strobe
   assert_vbl_waits_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (vbl_q && !vblank_i && !imm_q) |=> vbl_q);

   // R5: an immediate copy retires a deferred request pending with it
   assert_both_served_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (imm_q && vbl_q && !req_we) |=> (pend_o == 2'b00));
endmodule

// File: rtl/shr_irq_unit.sv
module shr_irq_unit
   import shr_pkg::*;
#(
   parameter bit IRQ_REG = 1'b0
) (
   input  logic  clk,
   input  logic  rst_n,
   input  flag_t ev_i,
   input  logic  ien_we,
   input  flag_t ien_data,
   input  logic  clr_we,
   input  flag_t clr_data,
   output flag_t status_o,
   output flag_t ien_o,
   output logic  irq_o
);
   flag_t status_q, status_d, ien_q, clr_mask;

   assign clr_mask = clr_we ? clr_data : '0;
   // events are ORed in after the clear, so an event beats a clear
   assign status_d = (status_q & ~clr_mask) | ev_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         status_q <= '0;
         ien_q    <= '0;
      end else begin
         status_q <= status_d;
         if (ien_we) ien_q <= ien_data;
      end
   end

   assign status_o = status_q;
   assign ien_o    = ien_q;

   if (IRQ_REG) begin : g_irq_reg
      logic irq_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq_q <= 1'b0;
         else        irq_q <= |(status_q & ien_q);
      end
      assign irq_o = irq_q;
   end else begin : g_irq_comb
      assign irq_o = |(status_q & ien_q);
   end

   // R7 and R9: every event bit is set after its edge, even when a clear hits it
   assert_event_sets_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_i != '0) |=> ((status_q & $past(ev_i)) == $past(ev_i)));

   // R8: bits cleared without a competing event read 0 afterwards
   assert_clear_works_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ((clr_mask & ~ev_i) != '0) |=> ((status_q & $past(clr_mask & ~ev_i)) == '0));
endmodule

// File: rtl/shadow_reload_irq.sv
module shadow_reload_irq
   import shr_pkg::*;
#(
   parameter int NUM_CFG = 4,
   parameter int DATA_W  = 16,
   parameter bit IRQ_REG = 1'b0,
   localparam int ADDR_W = $clog2(NUM_CFG + 3)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      wr_en,
   input  logic [ADDR_W-1:0]         wr_addr,
   input  logic [DATA_W-1:0]         wr_data,
   input  logic                      vblank_i,
   input  logic                      line_hit_i,
   input  logic                      fifo_urun_i,
   input  logic                      xfer_err_i,
   output logic [NUM_CFG*DATA_W-1:0] act_cfg_o,
   output logic                      irq_o,
   output logic [3:0]                status_o,
   output logic [3:0]                irq_en_o,
   output logic [1:0]                reload_pend_o
);
   localparam int ADR_RLD = NUM_CFG;
   localparam int ADR_IEN = NUM_CFG + 1;
   localparam int ADR_CLR = NUM_CFG + 2;

   if (NUM_CFG < 1) begin : g_bad_cfg
      $error("NUM_CFG must be at least 1");
   end
   if (DATA_W < NFLAG) begin : g_bad_width
      $error("DATA_W must hold every flag bit");
   end

   logic [NUM_CFG-1:0] cfg_sel;
   logic               rld_we, ien_we, clr_we, copy;
   flag_t              ev;

   for (genvar i = 0; i < NUM_CFG; i++) begin : g_sel
      assign cfg_sel[i] = wr_en && (wr_addr == ADDR_W'(i));
   end
   assign rld_we = wr_en && (wr_addr == ADDR_W'(ADR_RLD));
   assign ien_we = wr_en && (wr_addr == ADDR_W'(ADR_IEN));
   assign clr_we = wr_en && (wr_addr == ADDR_W'(ADR_CLR));

   shr_cfg_bank #(.NUM_CFG(NUM_CFG), .DATA_W(DATA_W)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_sel  (cfg_sel),
      .wr_data (wr_data),
      .copy_i  (copy),
      .act_o   (act_cfg_o)
   );

   shr_reload_seq u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .req_we   (rld_we),
      .req_bits (wr_data[1:0]),
      .vblank_i (vblank_i),
      .pend_o   (reload_pend_o),
      .copy_o   (copy)
   );

   always_comb begin
      ev           = '0;
      ev[FLG_LINE] = line_hit_i;
      ev[FLG_URUN] = fifo_urun_i;
      ev[FLG_XERR] = xfer_err_i;
      ev[FLG_RLD]  = copy;
   end

   shr_irq_unit #(.IRQ_REG(IRQ_REG)) u_irq (
      .clk      (clk),
      .rst_n    (rst_n),
      .ev_i     (ev),
      .ien_we   (ien_we),
      .ien_data (wr_data[NFLAG-1:0]),
      .clr_we   (clr_we),
      .clr_data (wr_data[NFLAG-1:0]),
      .status_o (status_o),
      .ien_o    (irq_en_o),
      .irq_o    (irq_o)
   );

   // R2: the active words move only on a copy
   assert_active_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !copy |=> $stable(act_cfg_o));

   // R6: each copy leaves the reload-done flag set
   assert_reload_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
      copy |=> status_o[FLG_RLD]);
endmodule

// File: tb/sim_shadow_reload_irq.sv
module sim_shadow_reload_irq;
   localparam int NCFG = 4;
   localparam int DW   = 16;
   localparam int NV   = 20;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            wr_en = 1'b0;
   logic [2:0]      wr_addr = '0;
   logic [DW-1:0]   wr_data = '0;
   logic            vblank = 1'b0, line_hit = 1'b0, urun = 1'b0, xerr = 1'b0;
   logic [NCFG*DW-1:0] act;
   logic            irq;
   logic [3:0]      status, ien;
   logic [1:0]      pend;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #2 clk = ~clk;

   shadow_reload_irq #(.NUM_CFG(NCFG), .DATA_W(DW), .IRQ_REG(1'b0)) u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .vblank_i(vblank), .line_hit_i(line_hit), .fifo_urun_i(urun), .xfer_err_i(xerr),
      .act_cfg_o(act), .irq_o(irq), .status_o(status), .irq_en_o(ien),
      .reload_pend_o(pend)
   );

   // row: we | addr[3] | data[16] | ev{vbl,line,urun,xerr} | exp status[4] | exp irq | exp pend{vbl,imm}
   localparam logic [30:0] VEC [NV] = '{
      {1'b1, 3'd5, 16'h000F, 4'b0000, 4'b0000, 1'b0, 2'b00},
      {1'b0, 3'd0, 16'h0000, 4'b0100, 4'b0001, 1'b1, 2'b00},
      {1'b0, 3'd0, 16'h0000, 4'b0010, 4'b0011, 1'b1, 2'b00},
      {1'b0, 3'd0, 16'h0000, 4'b0001, 4'b0111, 1'b1, 2'b00},
      {1'b1, 3'd6, 16'h0003, 4'b0000, 4'b0100, 1'b1, 2'b00},
      {1'b1, 3'd6, 16'h0004, 4'b0001, 4'b0100, 1'b1, 2'b00},
      {1'b1, 3'd6, 16'h0004, 4'b0000, 4'b0000, 1'b0, 2'b00},
      {1'b1, 3'd4, 16'h0001, 4'b0000, 4'b0000, 1'b0, 2'b01},
      {1'b0, 3'd0, 16'h0000, 4'b0000, 4'b1000, 1'b1, 2'b00},
      {1'b1, 3'd5, 16'h0001, 4'b0000, 4'b1000, 1'b0, 2'b00},
      {1'b1, 3'd6, 16'h0008, 4'b0000, 4'b0000, 1'b0, 2'b00},
      {1'b1, 3'd4, 16'h0002, 4'b0000, 4'b0000, 1'b0, 2'b10},
      {1'b0, 3'd0, 16'h0000, 4'b0000, 4'b0000, 1'b0, 2'b10},
      {1'b0, 3'd0, 16'h0000, 4'b1000, 4'b1000, 1'b0, 2'b00},
      {1'b1, 3'd4, 16'h0002, 4'b1000, 4'b1000, 1'b0, 2'b10},
      {1'b0, 3'd0, 16'h0000, 4'b0000, 4'b1000, 1'b0, 2'b10},
      {1'b0, 3'd0, 16'h0000, 4'b1000, 4'b1000, 1'b0, 2'b00},
      {1'b1, 3'd4, 16'h0003, 4'b0000, 4'b1000, 1'b0, 2'b11},
      {1'b0, 3'd0, 16'h0000, 4'b0000, 4'b1000, 1'b0, 2'b00},
      {1'b0, 3'd0, 16'h0000, 4'b0100, 4'b1001, 1'b1, 2'b00}
   };

   function automatic string row_tag(input int r);
      case (r)
         0, 9:          return "R10";
         1, 2, 3, 19:   return "R7";
         4, 6, 10:      return "R8";
         5:             return "R9";
         7:             return "R3";
         8:             return "R6";
         17, 18:        return "R5";
         default:       return "R4";
      endcase
   endfunction

   task automatic check(input string req, input string what, input logic [31:0] got,
                        input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, got, exp);
      end
   endtask

   // drive after a falling edge, sample 1 ns after the next rising edge
   task automatic apply(input logic we, input logic [2:0] a, input logic [DW-1:0] d,
                        input logic [3:0] ev);
      @(negedge clk);
      wr_en = we; wr_addr = a; wr_data = d;
      {vblank, line_hit, urun, xerr} = ev;
      @(posedge clk);
      #1;
   endtask

   function automatic logic [DW-1:0] word(input int w);
      return act[w*DW +: DW];
   endfunction

   task automatic check_reset_state(input string tag);
      for (int w = 0; w < NCFG; w++) check("R1", {tag, " active word"}, 32'(word(w)), 32'h0);
      check("R1", {tag, " status"}, 32'(status), 32'h0);
      check("R1", {tag, " enable"}, 32'(ien), 32'h0);
      check("R1", {tag, " pending"}, 32'(pend), 32'h0);
      check("R1", {tag, " irq"}, 32'(irq), 32'h0);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1;
      check_reset_state("in reset");
      @(negedge clk);
      rst_n = 1'b1;
      apply(1'b0, 3'd0, '0, 4'b0000);
      check_reset_state("after release");

      for (int r = 0; r < NV; r++) begin
         logic [30:0] v;
         v = VEC[r];
         apply(v[30], v[29:27], v[26:11], v[10:7]);
         check(row_tag(r), $sformatf("row %0d status", r), 32'(status), 32'(v[6:3]));
         check(row_tag(r), $sformatf("row %0d irq", r), 32'(irq), 32'(v[2]));
         check(row_tag(r), $sformatf("row %0d pending", r), 32'(pend), 32'(v[1:0]));
      end

      // R2: shadow writes do not reach the active words
      apply(1'b1, 3'd0, 16'hA5A5, 4'b0000);
      apply(1'b1, 3'd3, 16'h1234, 4'b0000);
      check("R2", "word0 after shadow write", 32'(word(0)), 32'h0);
      check("R2", "word3 after shadow write", 32'(word(3)), 32'h0);

      // R3: immediate copy lands one edge after the request
      apply(1'b1, 3'd4, 16'h0001, 4'b0000);
      check("R3", "word0 while pending", 32'(word(0)), 32'h0);
      check("R3", "pending set", 32'(pend), 32'h1);
      apply(1'b0, 3'd0, '0, 4'b0000);
      check("R3", "word0 copied", 32'(word(0)), 32'hA5A5);
      check("R3", "word3 copied", 32'(word(3)), 32'h1234);
      check("R3", "pending cleared", 32'(pend), 32'h0);

      // R4: deferred copy waits for the strobe
      apply(1'b1, 3'd1, 16'hBEEF, 4'b0000);
      apply(1'b1, 3'd4, 16'h0002, 4'b0000);
      for (int k = 0; k < 3; k++) begin
         apply(1'b0, 3'd0, '0, 4'b0000);
         check("R4", "word1 before strobe", 32'(word(1)), 32'h0);
      end
      apply(1'b0, 3'd0, '0, 4'b1000);
      check("R4", "word1 after strobe", 32'(word(1)), 32'hBEEF);
      check("R6", "reload flag after deferred copy", 32'(status[3]), 32'h1);

      // R2: a strobe with nothing pending changes nothing
      apply(1'b1, 3'd2, 16'h7777, 4'b0000);
      apply(1'b0, 3'd0, '0, 4'b1000);
      check("R2", "word2 after idle strobe", 32'(word(2)), 32'h0);
      check("R2", "word0 after idle strobe", 32'(word(0)), 32'hA5A5);

      // R1: reset in the middle of operation
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      check_reset_state("mid-run reset");
      @(negedge clk);
      rst_n = 1'b1;

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end
endmodule